// File: doc/BRIEF.md
# Viterbi Backtrace Sequencer

This block runs once a decoding pass has finished. During decoding it is fed one word per frame, each word holding the best predecessor state of every state in that frame. It keeps these words in an internal RAM. When the final frame has been scored, a start pulse hands the block the frame count and the final-frame score of every state. The block then recovers the most likely state path and streams it out.

Recovery takes three steps. First the block picks the best final state, with the lowest index winning a tie. It then walks the stored predecessor pointers backward, one frame per cycle, pushing each recovered state onto an internal stack. Once the walk reaches frame 0, it pops the stack over a valid/ready stream. The path therefore leaves in forward time order, and the last beat is flagged.

Top module: `trellis_backtrace`

## Requirements
- R1: After reset, `bt_busy` and `path_valid` are low. `path_valid` is never high while `bt_busy` is low.
- R2: The starting state is the index of the largest unsigned final score. State s occupies `final_scores[s*SCORE_W +: SCORE_W]`. When several scores are equal and largest, the lowest index is chosen.
- R3: The state at frame t-1 is the pointer stored in frame t's word at the field for the state at frame t. For state s, that field is `pred_wr_ptrs[s*STATE_W +: STATE_W]`. The walk runs from frame T-1 down to frame 1.
- R4: A run of T frames emits exactly T beats. They carry the states of frames 0, 1, ..., T-1 in that order, and `path_last` is high only on the frame T-1 beat.
- R5: While `path_valid` is high and `path_ready` is low, `path_valid`, `path_state` and `path_last` hold their values.
- R6: A start pulse while `bt_busy` is high is ignored. It changes neither the stream in progress nor the state after it finishes.
- R7: A start with `bt_frames` = 0 produces no beat, and `bt_busy` is low in the following cycle.
- R8: For T >= 1, `bt_busy` is high from the cycle after an accepted start until the final beat is accepted. `path_valid` first rises exactly T clock cycles after the start cycle.
- R9: A cycle with `pred_wr_en` high stores `pred_wr_ptrs` as the word of frame `pred_wr_frame`. Frame count T may be any value from 1 to N_FRAMES, including a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_wr_en | input | 1 | Write one frame of predecessor pointers |
| pred_wr_frame | input | FRAME_W | Frame index written |
| pred_wr_ptrs | input | N_STATES*STATE_W | Predecessor of every state, state s at bits s*STATE_W |
| bt_start | input | 1 | Begin a backtrace (taken only when idle) |
| bt_frames | input | CNT_W | Number of frames T in the utterance |
| final_scores | input | N_STATES*SCORE_W | Final-frame scores, state s at bits s*SCORE_W |
| bt_busy | output | 1 | A backtrace is in progress |
| path_valid | output | 1 | Stream beat available |
| path_ready | input | 1 | Consumer accepts the beat |
| path_state | output | STATE_W | Recovered state of the current frame |
| path_last | output | 1 | Beat carries the final frame's state |

## Verification
The assertions rely on three things about the inputs. Pointer writes happen only while the block is idle. `bt_frames` at an accepted start never exceeds the buffer depth. The score and pointer inputs are defined whenever a start is taken. The stimulus respects all three: it loads every frame of an utterance before pulsing start, uses frame counts from 0 to 256, and starts each bus at zero. It also drives the stray start pulses of R6 only while a run is active, and it throttles `path_ready` in some runs so that the hold rule is exercised.

// File: rtl/trellis_bt_pkg.sv
// Package: shared types for the backtrace sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package trellis_bt_pkg;

    // Control phase of the sequencer
    typedef enum logic [1:0] {
        BT_IDLE = 2'd0,
        BT_WALK = 2'd1,
        BT_EMIT = 2'd2
    } bt_phase_e;

endpackage

// File: rtl/bt_best_pick.sv
// Module: bt_best_pick
// Picks the index of the largest unsigned score through a linear compare
// chain. A later entry replaces the running best only when strictly
// greater, so a tie keeps the lowest index.
// Assumes: N_STATES >= 2, purely combinational, no clock.
module bt_best_pick #(
    parameter int N_STATES = 16,
    parameter int SCORE_W  = 16,
    localparam int STATE_W = $clog2(N_STATES)
) (
    input  logic [N_STATES*SCORE_W-1:0] scores_i,
    output logic [STATE_W-1:0]          best_idx_o,
    output logic [SCORE_W-1:0]          best_score_o
);

    logic [N_STATES-1:0][STATE_W-1:0] run_idx;
    logic [N_STATES-1:0][SCORE_W-1:0] run_val;

    // Stage 0 seeds the chain with state 0
    assign run_idx[0] = '0;
    assign run_val[0] = scores_i[SCORE_W-1:0];

    for (genvar i = 1; i < N_STATES; i++) begin : g_stage
        logic take;
        // Replace the running best only on a strictly larger score
        assign take       = scores_i[i*SCORE_W +: SCORE_W] > run_val[i-1];
        assign run_idx[i] = take ? STATE_W'(i) : run_idx[i-1];
        assign run_val[i] = take ? scores_i[i*SCORE_W +: SCORE_W] : run_val[i-1];
    end

    assign best_idx_o   = run_idx[N_STATES-1];
    assign best_score_o = run_val[N_STATES-1];

endmodule

// File: rtl/bt_pred_ram.sv
// Module: bt_pred_ram
// Single-write, single-read frame buffer of predecessor words with a
// registered read port (one cycle of latency).
// Assumes: a read and a write to the same address never coincide.
module bt_pred_ram #(
    parameter int N_FRAMES = 256,
    parameter int WORD_W   = 64,
    localparam int ADDR_W  = $clog2(N_FRAMES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [N_FRAMES];

    // Store one frame word per write cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read, data valid the cycle after rd_en
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/bt_lifo.sv
// Module: bt_lifo
// Last-in first-out store of recovered states. The top entry is visible
// combinationally. Push and pop never occur in the same cycle.
// Assumes: the caller never pushes when full or pops when empty
// (checked below).
module bt_lifo #(
    parameter int DEPTH   = 256,
    parameter int DATA_W  = 4,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] top_data,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] slots [DEPTH];

    // Write the pushed entry at the current fill level
    always_ff @(posedge clk) begin
        if (push) begin
            slots[ADDR_W'(count)] <= push_data;
        end
    end

    // Track the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push) begin
            count <= count + 1'b1;
        end else if (pop) begin
            count <= count - 1'b1;
        end
    end

    assign top_data = slots[ADDR_W'(count - 1'b1)];

    // R9: a full-depth path fits without overflow
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));

    // R4: the stream never pops past the bottom of the stack
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0) && !push);

endmodule

// File: rtl/trellis_backtrace.sv
// Module: trellis_backtrace (top)
// Recovers the most likely state path after decoding. At start it latches
// the best final state. It then reads one predecessor word per cycle,
// walking frame T-1 down to frame 1, and pushes each state on a stack.
// Finally it pops the stack over a valid/ready stream, frame 0 first.
// Assumes: predecessor writes only while idle, bt_frames <= N_FRAMES.
module trellis_backtrace
    import trellis_bt_pkg::*;
#(
    parameter int N_STATES = 16,
    parameter int N_FRAMES = 256,
    parameter int SCORE_W  = 16,
    localparam int STATE_W = $clog2(N_STATES),
    localparam int FRAME_W = $clog2(N_FRAMES),
    localparam int CNT_W   = $clog2(N_FRAMES + 1),
    localparam int WORD_W  = N_STATES * STATE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pred_wr_en,
    input  logic [FRAME_W-1:0]          pred_wr_frame,
    input  logic [WORD_W-1:0]           pred_wr_ptrs,
    input  logic                        bt_start,
    input  logic [CNT_W-1:0]            bt_frames,
    input  logic [N_STATES*SCORE_W-1:0] final_scores,
    output logic                        bt_busy,
    output logic                        path_valid,
    input  logic                        path_ready,
    output logic [STATE_W-1:0]          path_state,
    output logic                        path_last
);

    bt_phase_e          phase;
    logic [STATE_W-1:0] cur_state;
    logic [FRAME_W-1:0] cur_frame;
    logic [STATE_W-1:0] best_idx;
    logic [SCORE_W-1:0] best_score;
    logic [WORD_W-1:0]  rd_word;
    logic [STATE_W-1:0] ptr_sel;
    logic               take_start;
    logic               rd_en;
    logic [FRAME_W-1:0] rd_addr;
    logic               push;
    logic [STATE_W-1:0] push_data;
    logic               pop;
    logic [STATE_W-1:0] top_data;
    logic [CNT_W-1:0]   depth;

    bt_best_pick #(
        .N_STATES (N_STATES),
        .SCORE_W  (SCORE_W)
    ) u_pick (
        .scores_i     (final_scores),
        .best_idx_o   (best_idx),
        .best_score_o (best_score)
    );

    bt_pred_ram #(
        .N_FRAMES (N_FRAMES),
        .WORD_W   (WORD_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (pred_wr_en),
        .wr_addr (pred_wr_frame),
        .wr_data (pred_wr_ptrs),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    bt_lifo #(
        .DEPTH  (N_FRAMES),
        .DATA_W (STATE_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .top_data  (top_data),
        .count     (depth)
    );

    // Decode start acceptance, RAM reads, and stack traffic
    always_comb begin
        take_start = bt_start && (phase == BT_IDLE);
        ptr_sel    = rd_word[cur_state*STATE_W +: STATE_W];
        rd_en      = (take_start && (bt_frames != '0)) || (phase == BT_WALK);
        rd_addr    = (phase == BT_WALK) ? (cur_frame - 1'b1)
                                        : FRAME_W'(bt_frames - 1'b1);
        push       = (take_start && (bt_frames != '0)) || (phase == BT_WALK);
        push_data  = (phase == BT_WALK) ? ptr_sel : best_idx;
        pop        = (phase == BT_EMIT) && path_ready;
    end

    // Sequence idle, backward walk and forward emission
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= BT_IDLE;
            cur_state <= '0;
            cur_frame <= '0;
        end else begin
            unique case (phase)
                BT_IDLE: begin
                    if (take_start && (bt_frames != '0)) begin
                        cur_state <= best_idx;
                        cur_frame <= FRAME_W'(bt_frames - 1'b1);
                        phase     <= (bt_frames == CNT_W'(1)) ? BT_EMIT : BT_WALK;
                    end
                end
                BT_WALK: begin
                    cur_state <= ptr_sel;
                    cur_frame <= cur_frame - 1'b1;
                    if (cur_frame == FRAME_W'(1)) begin
                        phase <= BT_EMIT;
                    end
                end
                BT_EMIT: begin
                    if (pop && (depth == CNT_W'(1))) begin
                        phase <= BT_IDLE;
                    end
                end
                default: phase <= BT_IDLE;
            endcase
        end
    end

    assign bt_busy    = (phase != BT_IDLE);
    assign path_valid = (phase == BT_EMIT);
    assign path_state = top_data;
    assign path_last  = (depth == CNT_W'(1));

    // R1: nothing is offered while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bt_busy |-> !path_valid);

    // R5: a stalled beat holds
    p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        path_valid && !path_ready |=> path_valid && $stable(path_state) && $stable(path_last));

    // R4: the flagged beat ends the run
    p_last_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        path_valid && path_ready && path_last |=> !bt_busy);

    // R8: busy persists until the flagged beat is taken
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bt_busy && !(path_valid && path_ready && path_last) |=> bt_busy);

    // R7: an empty utterance returns to idle at once
    p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bt_start && !bt_busy && (bt_frames == '0) |=> !bt_busy);

    // R9: input rules: writes only while idle, count within depth
    p_idle_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bt_busy |-> !pred_wr_en);
    p_len_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bt_start && !bt_busy |-> bt_frames <= CNT_W'(N_FRAMES));

    for (genvar s = 0; s < N_STATES; s++) begin : g_chk
        // R2: the chosen start is no smaller than any score
        p_best_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
            bt_start && !bt_busy |-> final_scores[s*SCORE_W +: SCORE_W] <= best_score);
        // R2: lower indices than the pick score strictly less
        p_best_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
            bt_start && !bt_busy && (STATE_W'(s) < best_idx)
            |-> final_scores[s*SCORE_W +: SCORE_W] < best_score);
    end

endmodule

// File: tb/test_trellis_backtrace.sv
// Bench: scoreboard. The driver loads frames, computes the expected path
// and queues it. The monitor compares beats as they are accepted.
module test_trellis_backtrace;

    localparam int NS = 16;
    localparam int NF = 256;
    localparam int SW = 16;
    localparam int STW = 4;
    localparam int FW = 8;
    localparam int CW = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pred_wr_en = 1'b0;
    logic [FW-1:0]   pred_wr_frame = '0;
    logic [NS*STW-1:0] pred_wr_ptrs = '0;
    logic            bt_start = 1'b0;
    logic [CW-1:0]   bt_frames = '0;
    logic [NS*SW-1:0] final_scores = '0;
    logic            bt_busy;
    logic            path_valid;
    logic            path_ready = 1'b0;
    logic [STW-1:0]  path_state;
    logic            path_last;

    int n_run = 0;
    int n_fail = 0;
    int ptr_m [NF][NS];
    int sc [NS];
    int exp_state_q [$];
    bit exp_last_q [$];
    bit throttle = 1'b0;
    bit mon_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit prev_stall = 1'b0;
    logic [STW-1:0] prev_state = '0;
    logic prev_last = 1'b0;
    int cyc = 0;

    trellis_backtrace #(.N_STATES(NS), .N_FRAMES(NF), .SCORE_W(SW)) i_trellis_backtrace (
        .clk(clk), .rst_n(rst_n), .pred_wr_en(pred_wr_en), .pred_wr_frame(pred_wr_frame),
        .pred_wr_ptrs(pred_wr_ptrs), .bt_start(bt_start), .bt_frames(bt_frames),
        .final_scores(final_scores), .bt_busy(bt_busy), .path_valid(path_valid),
        .path_ready(path_ready), .path_state(path_state), .path_last(path_last));

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_up();
        end
    end

    // Monitor: drive ready, check stalls (R5), compare accepted beats (R3, R4)
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_stall) begin
                chk(path_valid && path_state == prev_state && path_last == prev_last,
                    "R5 hold", int'(path_state), int'(prev_state));
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            path_ready = throttle ? lfsr[0] : 1'b1;
            if (path_valid && path_ready) begin
                if (exp_state_q.size() == 0) begin
                    chk(1'b0, "R4 extra beat", int'(path_state), -1);
                end else begin
                    int es;
                    bit el;
                    es = exp_state_q.pop_front();
                    el = exp_last_q.pop_front();
                    chk(int'(path_state) == es, "R3 path state", int'(path_state), es);
                    chk(path_last == el, "R4 last flag", int'(path_last), int'(el));
                end
            end
            prev_stall = path_valid && !path_ready;
            prev_state = path_state;
            prev_last = path_last;
        end
    end

    // Fill T frames with hashed pointers (R9 write port)
    task automatic load_frames(input int t_len, input int seed);
        for (int t = 0; t < t_len; t++) begin
            logic [NS*STW-1:0] w;
            w = '0;
            for (int s = 0; s < NS; s++) begin
                logic [31:0] h;
                h = 32'(seed) * 32'd1103515245 + 32'(t) * 32'd40503 + 32'(s) * 32'd2654435 + 32'd12345;
                h = h ^ (h >> 13);
                ptr_m[t][s] = int'(h[19:16]);
                w[s*STW +: STW] = h[19:16];
            end
            @(negedge clk);
            pred_wr_en = 1'b1;
            pred_wr_frame = FW'(t);
            pred_wr_ptrs = w;
        end
        @(negedge clk);
        pred_wr_en = 1'b0;
    endtask

    // Queue the expected path, start the run, check busy and latency (R2, R8)
    task automatic run_utt(input int t_len, input bit inject, input string tag);
        int path [NF];
        int best;
        int k;
        best = 0;
        for (int s = 1; s < NS; s++) if (sc[s] > sc[best]) best = s;
        if (t_len > 0) begin
            path[t_len-1] = best;
            for (int t = t_len - 1; t >= 1; t--) path[t-1] = ptr_m[t][path[t]];
            for (int t = 0; t < t_len; t++) begin
                exp_state_q.push_back(path[t]);
                exp_last_q.push_back(t == t_len - 1);
            end
        end
        @(negedge clk);
        bt_start = 1'b1;
        bt_frames = CW'(t_len);
        for (int s = 0; s < NS; s++) final_scores[s*SW +: SW] = SW'(sc[s]);
        @(negedge clk);
        bt_start = 1'b0;
        if (t_len == 0) begin
            chk(!bt_busy, "R7 busy after empty start", int'(bt_busy), 0);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(!path_valid && !bt_busy, "R7 no output", int'(path_valid), 0);
            end
            return;
        end
        chk(bt_busy, {"R8 busy after start ", tag}, int'(bt_busy), 1);
        k = 1;
        while (!path_valid) begin
            @(negedge clk);
            k++;
        end
        chk(k == t_len, {"R8 latency ", tag}, k, t_len);
        if (inject) begin
            bt_start = 1'b1;
            bt_frames = CW'(5);
            final_scores = '1;
            @(negedge clk);
            bt_start = 1'b0;
            final_scores = '0;
        end
        while (exp_state_q.size() != 0 || bt_busy) @(negedge clk);
        if (inject) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(!path_valid && !bt_busy, "R6 stray start ignored", int'(path_valid), 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bt_busy, "R1 reset busy", int'(bt_busy), 0);
        chk(!path_valid, "R1 reset valid", int'(path_valid), 0);
        mon_on = 1'b1;

        // R2 unique max at state 7, R3 walk over 20 frames
        for (int s = 0; s < NS; s++) sc[s] = 100 + s * 3;
        sc[7] = 9000;
        load_frames(20, 1);
        run_utt(20, 1'b0, "T20");

        // R2 tie between states 3 and 9: lowest wins
        for (int s = 0; s < NS; s++) sc[s] = 50;
        sc[3] = 60000; sc[9] = 60000;
        load_frames(12, 2);
        run_utt(12, 1'b0, "tie");

        // R2 all equal -> state 0, single frame
        for (int s = 0; s < NS; s++) sc[s] = 777;
        load_frames(1, 3);
        run_utt(1, 1'b0, "T1");

        // R2 max at the top state, unsigned top range; R5 throttled ready
        for (int s = 0; s < NS; s++) sc[s] = s * 1000;
        sc[15] = 65535;
        throttle = 1'b1;
        load_frames(37, 4);
        run_utt(37, 1'b0, "stall");

        // R6 start while busy
        for (int s = 0; s < NS; s++) sc[s] = (s * 7919) % 4096;
        load_frames(9, 5);
        run_utt(9, 1'b1, "inject");
        throttle = 1'b0;

        // R7 zero frames
        run_utt(0, 1'b0, "T0");

        // R9 full buffer, two frames
        for (int s = 0; s < NS; s++) sc[s] = (s * 37) % 91;
        load_frames(NF, 6);
        throttle = 1'b1;
        run_utt(NF, 1'b0, "full");
        throttle = 1'b0;
        load_frames(2, 7);
        run_utt(2, 1'b0, "T2");

        repeat (3) @(negedge clk);
        chk(exp_state_q.size() == 0, "R4 all beats seen", exp_state_q.size(), 0);
        finish_up();
    end

endmodule